// File: doc/BRIEF.md
# Programmable Reflected CRC Engine

This block computes a cyclic redundancy check over a stream of data words that a host writes into it one at a time. The generator polynomial is programmable and is held in reflected form: the implied top term is left out, and the coefficient of the highest remaining power sits in bit 0. Each data word is absorbed least significant bit first by a right-shifting update. A whole word is folded into the running state in a single clock cycle.

The host reaches the block through a single write port that carries a two-bit register select. It can load the polynomial, preset the running state to any seed, or push a data word. The running state and the polynomial are always visible on output ports. The state comes out of reset as all ones. The hardware never inverts the result, so any final complement is applied by the consumer.

A narrower check, such as a 16-bit one, is obtained by programming a polynomial and a seed whose upper bits are zero. The result is then read from the low bits of the state.

Top module: `crc_engine`

## Requirements
- R1: After reset the state output is all ones and the polynomial output equals the parameter POLY_RESET (default 0xEDB88320).
- R2: A write with select 1 stores the write data as the polynomial. The new value appears on the polynomial output one clock later.
- R3: A write with select 2 loads the write data into the state. The new value appears on the state output one clock later.
- R4: A write with select 0 replaces the state, one clock later, with the result of DATA_W single-bit steps taken from bit 0 upward. Each step computes f = state[0] XOR data bit, shifts the state right by one with a zero entering the top, and XORs in the polynomial when f is 1.
- R5: A zero state that absorbs a zero data word stays zero.
- R6: With the polynomial 0xEDB88320 and an all-ones seed, absorbing any message followed by the bitwise inverse of its resulting state leaves the state at 0xDEBB20E3.
- R7: A write with select 3, or a cycle with no write, leaves both the state and the polynomial unchanged.
- R8: When the polynomial and the seed have zero upper bits (for example 0x0000A001 and 0x0000FFFF), the upper 16 state bits remain zero. The low 16 bits then follow the 16-bit reflected update.
- R9: A data word is always processed with the polynomial held at the moment of its write. A polynomial write applies only to data words written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 polynomial, 2 state, 3 unused |
| wr_data | input | DATA_W | Write data |
| crc_value | output | CRC_W | Running CRC state, not inverted |
| poly_value | output | CRC_W | Programmed reflected polynomial |

## Verification
The hardest condition to reach is the residue property. It only appears after a message has been absorbed and its own inverted checksum has been written back as a further data word, so the stimulus has to read the state mid-run and feed its complement back in. The bench does this for several random message lengths. The polynomial-switch ordering is reached by placing a polynomial write directly between two data writes. A second, 8-bit instance is swept over all 256 data values so that the single-cycle unrolled update is covered exhaustively.

// File: rtl/crc_pkg.sv
package crc_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_POLY = 2'd1,
      SEL_SEED = 2'd2,
      SEL_NONE = 2'd3
   } crc_sel_e;

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
   parameter int CRC_W = 32
) (
   input  logic [CRC_W-1:0] state_i,
   input  logic [CRC_W-1:0] poly_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] state_o
);

   logic fold;

   always_comb begin
      fold    = state_i[0] ^ bit_i;
      state_o = (state_i >> 1) ^ (fold ? poly_i : '0);
   end

endmodule

// File: rtl/crc_word_update.sv
module crc_word_update #(
   parameter int CRC_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic [CRC_W-1:0]  state_i,
   input  logic [CRC_W-1:0]  poly_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  state_o
);

   localparam int STAGES = DATA_W;

   logic [CRC_W-1:0] chain [STAGES+1];

   assign chain[0] = state_i;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_step
         crc_bit_step #(.CRC_W(CRC_W)) u_step (
            .state_i (chain[g]),
            .poly_i  (poly_i),
            .bit_i   (data_i[g]),
            .state_o (chain[g+1])
         );
      end
   endgenerate

   assign state_o = chain[STAGES];

endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter int              CRC_W      = 32,
   parameter int              DATA_W     = 32,
   parameter logic [CRC_W-1:0] POLY_RESET = CRC_W'(32'hEDB88320)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CRC_W-1:0]  crc_value,
   output logic [CRC_W-1:0]  poly_value
);
   import crc_pkg::*;

   localparam logic [CRC_W-1:0] STATE_RESET = '1;

   generate
      if (CRC_W < 1 || CRC_W > 32) begin : g_bad_crc_w
         $error("crc_engine: CRC_W must lie in 1..32");
      end
      if (DATA_W < CRC_W) begin : g_bad_data_w
         $error("crc_engine: DATA_W must be at least CRC_W");
      end
   endgenerate

   crc_sel_e         sel;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] poly_q;
   logic [CRC_W-1:0] crc_next;
   logic [CRC_W-1:0] wr_low;

   assign sel    = crc_sel_e'(wr_addr);
   assign wr_low = wr_data[CRC_W-1:0];

   crc_word_update #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_update (
      .state_i (crc_q),
      .poly_i  (poly_q),
      .data_i  (wr_data),
      .state_o (crc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q  <= STATE_RESET;
         poly_q <= POLY_RESET;
      end else if (wr_en) begin
         unique case (sel)
            SEL_DATA: crc_q  <= crc_next;
            SEL_POLY: poly_q <= wr_low;
            SEL_SEED: crc_q  <= wr_low;
            default:  ;
         endcase
      end
   end

   assign crc_value  = crc_q;
   assign poly_value = poly_q;

   // R2
   poly_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> poly_value == $past(wr_data[CRC_W-1:0]));

   // R3
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> crc_value == $past(wr_data[CRC_W-1:0]));

   // R5
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0 && crc_value == '0 && wr_data == '0) |=> crc_value == '0);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr == 2'd3) |=> ($stable(crc_value) && $stable(poly_value)));

   // R9
   poly_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> $stable(poly_value));

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [1:0]  wr_addr = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] crc_value, poly_value;

   logic        wr_en8 = 0;
   logic [1:0]  wr_addr8 = 0;
   logic [7:0]  wr_data8 = 0;
   logic [7:0]  crc8, poly8;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_engine u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .crc_value(crc_value), .poly_value(poly_value));

   crc_engine #(.CRC_W(8), .DATA_W(8), .POLY_RESET(8'h8C)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en8), .wr_addr(wr_addr8),
      .wr_data(wr_data8), .crc_value(crc8), .poly_value(poly8));

   function automatic logic [31:0] ref_crc(logic [31:0] s, logic [31:0] p,
                                           logic [31:0] d, int nbits);
      logic [31:0] r = s;
      for (int i = 0; i < nbits; i++) begin
         if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ p;
         else                       r = r >> 1;
      end
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wr8(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en8 = 1; wr_addr8 = a; wr_data8 = d;
      @(negedge clk);
      wr_en8 = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] exp, w, c;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 state", crc_value, 32'hFFFFFFFF);
      check("R1 poly", poly_value, 32'hEDB88320);
      check("R1 state8", {24'd0, crc8}, 32'hFF);

      // R2 polynomial write
      wr(2'd1, 32'h82F63B78);
      check("R2", poly_value, 32'h82F63B78);
      wr(2'd1, 32'hEDB88320);

      // R3 seed write
      wr(2'd2, 32'h12345678);
      check("R3", crc_value, 32'h12345678);

      // R4 single-bit data words from zero seed
      for (int b = 0; b < 32; b++) begin
         wr(2'd2, 32'h0);
         wr(2'd0, 32'h1 << b);
         check("R4 onehot", crc_value, ref_crc(32'h0, 32'hEDB88320, 32'h1 << b, 32));
      end

      // R4 random sequences
      exp = 32'hFFFFFFFF;
      wr(2'd2, exp);
      for (int i = 0; i < 40; i++) begin
         w = $urandom;
         wr(2'd0, w);
         exp = ref_crc(exp, 32'hEDB88320, w, 32);
         check("R4 random", crc_value, exp);
      end

      // R5 zero seed and zero data
      wr(2'd2, 32'h0);
      for (int i = 0; i < 4; i++) wr(2'd0, 32'h0);
      check("R5", crc_value, 32'h0);

      // R6 residue over several message lengths
      for (int n = 1; n <= 5; n++) begin
         wr(2'd2, 32'hFFFFFFFF);
         for (int i = 0; i < n; i++) wr(2'd0, $urandom);
         c = crc_value;
         wr(2'd0, ~c);
         check("R6", crc_value, 32'hDEBB20E3);
      end

      // R7 unused select and idle cycles
      wr(2'd2, 32'hA5A5_0F0F);
      wr(2'd3, 32'h0000_0000);
      repeat (3) @(negedge clk);
      check("R7 state", crc_value, 32'hA5A5_0F0F);
      check("R7 poly", poly_value, 32'hEDB88320);

      // R8 narrow 16-bit configuration
      wr(2'd1, 32'h0000A001);
      wr(2'd2, 32'h0000FFFF);
      exp = 32'h0000FFFF;
      for (int i = 0; i < 20; i++) begin
         w = $urandom;
         wr(2'd0, w);
         exp = ref_crc(exp, 32'h0000A001, w, 32);
         check("R8 upper", {16'd0, crc_value[31:16]}, 32'h0);
         check("R8 low", crc_value, exp);
      end

      // R9 polynomial switch between data words
      wr(2'd1, 32'hEDB88320);
      wr(2'd2, 32'hFFFFFFFF);
      wr(2'd0, 32'hCAFEF00D);
      exp = ref_crc(32'hFFFFFFFF, 32'hEDB88320, 32'hCAFEF00D, 32);
      check("R9 old poly", crc_value, exp);
      wr(2'd1, 32'h82F63B78);
      check("R9 state kept", crc_value, exp);
      wr(2'd0, 32'h01234567);
      exp = ref_crc(exp, 32'h82F63B78, 32'h01234567, 32);
      check("R9 new poly", crc_value, exp);

      // R4 exhaustive sweep of the 8-bit instance
      for (int d = 0; d < 256; d++) begin
         wr8(2'd2, 8'hFF);
         wr8(2'd0, d[7:0]);
         check("R4 sweep8", {24'd0, crc8},
               ref_crc(32'hFF, 32'h8C, 32'(d), 8));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule